// File: doc/BRIEF.md
# Audio Bit-Clock and Codec Master-Clock Divider

This block turns one incoming audio reference clock into two derived clocks: a serial bit clock for an audio serial link running as master, and a master clock for an external codec. Both ratios come from one 32-bit control word, which is written and read through a small synchronous register port. An enable input starts and stops both outputs together.

The bit clock always divides by an even ratio of twice the field value plus one. The codec clock divides by twice its field value. A field value of zero selects bypass instead, and the reference clock is then passed straight through. Both divided outputs have a 50% duty cycle. A ratio written while the clocks run is taken up only when the current half period ends. Moving the codec clock into or out of bypass goes through a glitch-free selector, so no short pulse appears on the output.

Top module: `aclk_divpair`

## Requirements
- R1: After reset the control word reads zero, the codec clock is in bypass and, once enabled, the bit clock toggles on every input clock cycle. Both outputs are low while reset is held.
- R2: The control word is at byte address 0x04. A write takes effect on the next clock edge and reads back at that address. Writes to any other address are ignored, and reads from any other address return zero.
- R3: Only bits [15:8] (bit-clock field) and [2:0] (codec-clock field) are stored. All other bits read as zero, and writing ones to them has no effect.
- R4: With bit-clock field B, each high and each low phase of the bit clock lasts B+1 input cycles.
- R5: With codec-clock field M from 1 to 7, each high and each low phase of the codec clock lasts M input cycles.
- R6: With M = 0 the codec clock equals the input clock: high in the input's high phase, low in its low phase.
- R7: A new bit-clock field written while running is applied only when the current phase ends, so the phase in progress keeps its old length.
- R8: When the codec clock switches between bypass and divided mode, or between two divide ratios, every high pulse it gives is complete. It is either one input high phase or M full input cycles. The two clock sources are never selected at the same time.
- R9: While the enable is low, both outputs are low and both counters stay at zero. After the enable rises, the first bit-clock rising edge comes B+1 cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Audio reference clock; it also clocks the register port |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Runs both dividers when high |
| wr_i | input | 1 | Write strobe for the control word |
| addr_i | input | ADDR_W (8) | Byte address for read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the address on addr_i |
| bclk_o | output | 1 | Serial bit clock |
| mclk_o | output | 1 | Codec master clock |

## Verification
The assertions assume a free-running reference clock. They also assume that en_i, wr_i, addr_i and wdata_i change only away from both clock edges, because the selector flops update on the falling edge and the counters update on the rising edge. The stimulus changes every input three time units after a rising edge, well clear of both edges. It samples each output one time unit after each edge. This lets the codec clock be observed in its high and its low half cycle, so bypass and complete-pulse checks can be made.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
   localparam int unsigned CTRL_W = 32;
   typedef logic [CTRL_W-1:0] ctrl_word_t;

   // bit mask covering w bits starting at lsb
   function automatic ctrl_word_t field_mask(input int unsigned lsb, input int unsigned w);
      ctrl_word_t m;
      m = '0;
      for (int unsigned i = 0; i < CTRL_W; i++) begin
         if (i >= lsb && i < lsb + w) m[i] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/aclk_regs.sv
module aclk_regs
   import aclk_pkg::*;
#(
   parameter int unsigned        ADDR_W   = 8,
   parameter logic [ADDR_W-1:0]  CTRL_OFS = 8'h04,
   parameter int unsigned        BDIV_W   = 8,
   parameter int unsigned        BDIV_LSB = 8,
   parameter int unsigned        MDIV_W   = 3,
   parameter int unsigned        MDIV_LSB = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  ctrl_word_t        wdata_i,
   output ctrl_word_t        rdata_o,
   output logic [BDIV_W-1:0] bdiv_o,
   output logic [MDIV_W-1:0] mdiv_o
);
   localparam ctrl_word_t KEEP = field_mask(BDIV_LSB, BDIV_W) | field_mask(MDIV_LSB, MDIV_W);

   ctrl_word_t ctrl_q;
   logic       hit;

   assign hit = (addr_i == CTRL_OFS);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        ctrl_q <= '0;
      else if (wr_i && hit) ctrl_q <= wdata_i & KEEP;
   end

   assign rdata_o = hit ? ctrl_q : '0;
   assign bdiv_o  = ctrl_q[BDIV_LSB +: BDIV_W];
   assign mdiv_o  = ctrl_q[MDIV_LSB +: MDIV_W];
endmodule

// File: rtl/aclk_div_ctr.sv
// Toggle divider. PLUS_ONE=1: half period = field+1 cycles.
// PLUS_ONE=0: half period = field cycles, field 0 means idle (bypass requested).
module aclk_div_ctr #(
   parameter int unsigned W        = 8,
   parameter bit          PLUS_ONE = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         run_i,
   input  logic [W-1:0] field_i,
   output logic         clk_o,
   output logic         idle_o
);
   logic [W-1:0] cnt_q;
   logic [W-1:0] cur_q;
   logic [W-1:0] last;
   logic         out_q;
   logic         term;
   logic         park;

   generate
      if (PLUS_ONE) begin : g_plus_one
         assign last   = cur_q;
         assign idle_o = 1'b0;
         assign park   = 1'b0;
      end else begin : g_even
         assign last   = cur_q - W'(1);
         assign idle_o = (cur_q == '0);
         assign park   = (field_i == '0);
      end
   endgenerate

   assign term = (cnt_q == last);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         cur_q <= '0;
         out_q <= 1'b0;
      end else if (!run_i || idle_o) begin
         cnt_q <= '0;
         cur_q <= field_i;
         out_q <= 1'b0;
      end else if (term) begin
         cnt_q <= '0;
         cur_q <= field_i;
         out_q <= park ? 1'b0 : ~out_q;
      end else begin
         cnt_q <= cnt_q + W'(1);
      end
   end

   assign clk_o = out_q;
endmodule

// File: rtl/aclk_gmux.sv
// Glitch-free two-source selector; selection flops move on the falling edge
module aclk_gmux (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic byp_req_i,
   input  logic div_clk_i,
   output logic mclk_o
);
   logic byp_q;
   logic div_q;

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         byp_q <= 1'b0;
         div_q <= 1'b0;
      end else begin
         byp_q <= run_i & byp_req_i & ~div_q;
         if (!div_clk_i) div_q <= run_i & ~byp_req_i & ~byp_q;
      end
   end

   assign mclk_o = (clk_i & byp_q) | (div_clk_i & div_q);
endmodule

// File: rtl/aclk_divpair.sv
module aclk_divpair
   import aclk_pkg::*;
#(
   parameter int unsigned        ADDR_W   = 8,
   parameter logic [ADDR_W-1:0]  CTRL_OFS = 8'h04,
   parameter int unsigned        BDIV_W   = 8,
   parameter int unsigned        BDIV_LSB = 8,
   parameter int unsigned        MDIV_W   = 3,
   parameter int unsigned        MDIV_LSB = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rdata_o,
   output logic              bclk_o,
   output logic              mclk_o
);
   localparam ctrl_word_t CTRL_MASK = field_mask(BDIV_LSB, BDIV_W) | field_mask(MDIV_LSB, MDIV_W);

   generate
      if (BDIV_LSB + BDIV_W > CTRL_W || MDIV_LSB + MDIV_W > CTRL_W) begin : g_bad_fit
         $error("divider field exceeds control word");
      end
      if ((field_mask(BDIV_LSB, BDIV_W) & field_mask(MDIV_LSB, MDIV_W)) != '0) begin : g_bad_overlap
         $error("divider fields overlap");
      end
      if (BDIV_W == 0 || MDIV_W == 0) begin : g_bad_width
         $error("divider field width must be nonzero");
      end
   endgenerate

   logic [BDIV_W-1:0] bdiv;
   logic [MDIV_W-1:0] mdiv;
   logic              mdiv_clk;
   logic              m_idle;
   logic              b_idle_unused;
   logic              run_q;

   aclk_regs #(
      .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS),
      .BDIV_W(BDIV_W), .BDIV_LSB(BDIV_LSB),
      .MDIV_W(MDIV_W), .MDIV_LSB(MDIV_LSB)
   ) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .rdata_o(rdata_o), .bdiv_o(bdiv), .mdiv_o(mdiv)
   );

   aclk_div_ctr #(.W(BDIV_W), .PLUS_ONE(1'b1)) u_bdiv (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(en_i), .field_i(bdiv),
      .clk_o(bclk_o), .idle_o(b_idle_unused)
   );

   aclk_div_ctr #(.W(MDIV_W), .PLUS_ONE(1'b0)) u_mdiv (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(en_i), .field_i(mdiv),
      .clk_o(mdiv_clk), .idle_o(m_idle)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) run_q <= 1'b0;
      else         run_q <= en_i;
   end

   aclk_gmux u_mux (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q),
      .byp_req_i(m_idle), .div_clk_i(mdiv_clk), .mclk_o(mclk_o)
   );
endmodule

// File: rtl/aclk_divpair_chk.sv
module aclk_divpair_chk #(
   parameter int unsigned       ADDR_W = 8,
   parameter logic [ADDR_W-1:0] OFS    = 8'h04,
   parameter logic [31:0]       MASK   = 32'h0000_FF07
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              wr,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       rdata,
   input logic              bclk,
   input logic              byp_sel,
   input logic              div_sel,
   input logic              div_clk
);
   assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata & ~MASK) == 32'h0);

   assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == OFS && $past(addr == OFS) && !$past(wr)) |-> $stable(rdata));

   assert_stopped_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !bclk);

   assert_rise_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bclk) |-> $past(en));

   assert_single_source_R8: assert property (@(negedge clk) disable iff (!rst_n)
      !(byp_sel && div_sel));

   assert_switch_when_low_R8: assert property (@(negedge clk) disable iff (!rst_n)
      ($rose(div_sel) || $fell(div_sel)) |-> !$past(div_clk));
endmodule

bind aclk_divpair aclk_divpair_chk #(
   .ADDR_W(ADDR_W), .OFS(CTRL_OFS), .MASK(CTRL_MASK)
) u_chk (
   .clk(clk_i), .rst_n(rst_ni), .en(en_i), .wr(wr_i), .addr(addr_i),
   .rdata(rdata_o), .bclk(bclk_o),
   .byp_sel(u_mux.byp_q), .div_sel(u_mux.div_q), .div_clk(mdiv_clk)
);

// File: tb/aclk_divpair_test.sv
module aclk_divpair_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        wr = 1'b0;
   logic [7:0]  addr = 8'h04;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        bclk;
   logic        mclk;

   int tests = 0;
   int fails = 0;
   bit done = 0;
   string tag = "R1";

   // behavioural reference state
   int unsigned reg_m = 0;
   int b_lim = 0, b_cnt = 0, b_lvl = 0;
   int hrun = 0;
   int hruns[$];

   always #2 clk = ~clk;

   aclk_divpair uut (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .wr_i(wr), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .bclk_o(bclk), .mclk_o(mclk)
   );

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // per-clock reference: bit clock and read data
   always @(posedge clk) begin
      if (!rst_n) begin
         reg_m = 0; b_lim = 0; b_cnt = 0; b_lvl = 0;
      end else begin
         if (!en) begin
            b_cnt = 0; b_lvl = 0; b_lim = (reg_m >> 8) & 255;
         end else if (b_cnt == b_lim) begin
            b_lvl = 1 - b_lvl; b_cnt = 0; b_lim = (reg_m >> 8) & 255;
         end else b_cnt++;
         if (wr && addr == 8'h04) reg_m = wdata & 32'h0000_FF07;
      end
      #1;
      if (!done) begin
         check({tag, " bclk"}, int'(bclk), b_lvl);
         check({tag, " rdata"}, int'(rdata), (addr == 8'h04) ? int'(reg_m) : 0);
      end
   end

   // codec clock high-run monitor, two samples per cycle
   always @(posedge clk or negedge clk) begin
      #1;
      if (mclk) hrun++;
      else if (hrun > 0) begin hruns.push_back(hrun); hrun = 0; end
   end

   task automatic drive_edge();
      @(posedge clk); #3;
   endtask

   task automatic write(input logic [7:0] a, input logic [31:0] d);
      drive_edge();
      wr = 1'b1; addr = a; wdata = d;
      drive_edge();
      wr = 1'b0; addr = 8'h04;
   endtask

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) drive_edge();
   endtask

   // every complete high run (first one dropped) must be a or b half-samples
   task automatic check_runs(input string req, input int a, input int b, input int min_n);
      int n;
      n = 0;
      foreach (hruns[i]) begin
         if (i > 0) begin
            n++;
            check(req, hruns[i], (hruns[i] == b) ? b : a);
         end
      end
      tests++;
      if (n < min_n) begin
         fails++;
         $display("FAIL %s: actual %0d runs expected at least %0d", req, n, min_n);
      end
   endtask

   task automatic check_both_low(input int cycles);
      for (int i = 0; i < cycles; i++) begin
         @(posedge clk); #1;
         check("R9 bclk", int'(bclk), 0);
         check("R9 mclk high phase", int'(mclk), 0);
         @(negedge clk); #1;
         check("R9 mclk low phase", int'(mclk), 0);
      end
   endtask

   initial begin
      // R1: state while reset is held
      #5;
      check("R1 reset bclk", int'(bclk), 0);
      check("R1 reset mclk", int'(mclk), 0);
      check("R1 reset rdata", int'(rdata), 0);
      drive_edge();
      rst_n = 1'b1;
      wait_cycles(3);

      // R1/R6: enabled out of reset, bit clock at half rate, codec clock bypass
      tag = "R1";
      en = 1'b1;
      wait_cycles(6);
      hruns.delete();
      wait_cycles(20);
      check_runs("R6 bypass", 1, 1, 10);

      // R4: bit clock divide
      tag = "R4";
      write(8'h04, 32'h0000_0300);
      wait_cycles(40);

      // R3: reserved bits dropped
      tag = "R3";
      write(8'h04, 32'hFFFF_FFFF);
      @(posedge clk); #1;
      check("R3 readback", int'(rdata), 32'h0000_FF07);
      write(8'h04, 32'hFFFF_00F8);
      @(posedge clk); #1;
      check("R3 reserved only", int'(rdata), 32'h0);

      // R2: other addresses ignored
      tag = "R2";
      write(8'h04, 32'h0000_0203);
      write(8'h08, 32'h0000_0507);
      write(8'h05, 32'h0000_0101);
      drive_edge();
      addr = 8'h08;
      @(posedge clk); #1;
      check("R2 other read", int'(rdata), 0);
      #2 addr = 8'h04;
      @(posedge clk); #1;
      check("R2 kept", int'(rdata), 32'h0000_0203);

      // R5: divided codec clock, several ratios
      tag = "R5";
      for (int m = 1; m <= 7; m += 3) begin
         write(8'h04, 32'h0000_0200 | m);
         wait_cycles(4 * m + 6);
         hruns.delete();
         wait_cycles(10 * m + 4);
         check_runs("R5 divided", 2 * m, 2 * m, 3);
      end

      // R8: ratio change and bypass switching give only full pulses
      tag = "R8";
      write(8'h04, 32'h0000_0203);
      wait_cycles(20);
      hruns.delete();
      wait_cycles(4);
      write(8'h04, 32'h0000_0202);
      wait_cycles(30);
      check_runs("R8 ratio change", 6, 4, 4);
      hruns.delete();
      wait_cycles(5);
      write(8'h04, 32'h0000_0200);
      wait_cycles(20);
      check_runs("R8 to bypass", 4, 1, 5);
      hruns.delete();
      wait_cycles(3);
      write(8'h04, 32'h0000_0201);
      wait_cycles(20);
      check_runs("R8 from bypass", 1, 2, 5);

      // R7: bit clock ratio changed mid-phase
      tag = "R7";
      write(8'h04, 32'h0000_0900);
      wait_cycles(25);
      write(8'h04, 32'h0000_0100);
      wait_cycles(30);
      write(8'h04, 32'h0000_0600);
      wait_cycles(3);
      write(8'h04, 32'h0000_0000);
      wait_cycles(20);

      // R9: disable, hold low, restart
      tag = "R9";
      write(8'h04, 32'h0000_0400);
      wait_cycles(7);
      en = 1'b0;
      wait_cycles(2);
      check_both_low(12);
      write(8'h04, 32'h0000_0200);
      check_both_low(4);
      drive_edge();
      en = 1'b1;
      wait_cycles(20);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule